// File: doc/BRIEF.md
# Keyed configuration port controller

This block sits behind a host I/O bus and exposes a legacy configuration space through two byte ports: an index port at a strapped base address and a data port at the next address. The host writes a register number to the index port and then reads or writes that register through the data port. A small set of registers lives inside the block: the index itself, a logical-device selector and read-only identification bytes. Register numbers from 0x30 upward belong to whichever logical device is selected and are passed out on a simple register port.

The configuration space is guarded by a key. Until the host writes 0x87 to the index port on two index writes in a row, the space stays shut. While it is shut, writes to the data port do nothing and every port read returns 0xFF. Writing 0xAA to the index port while the space is open shuts it again. Host requests arrive on a valid/ready channel. Every accepted read produces exactly one response beat on a second valid/ready channel. Only one read response can be outstanding, so a stalled response channel also stalls the request channel.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is shut, the index register and the device selector are 0x00, no response is pending and `req_ready` is 1.
- R2: The space opens only after two consecutive index-port writes of 0x87. Any other value written to the index port while shut restarts the count. Data-port writes neither advance nor restart it.
- R3: An index-port write of 0xAA while open shuts the space and leaves the index register unchanged. Afterwards all reads return 0xFF.
- R4: While shut, data-port writes change no register and raise no `ld_we`, and reads of either port return 0xFF.
- R5: While open, an index-port write of any value other than 0xAA loads the index register, and an index-port read returns it.
- R6: Register 0x07 is the device selector. While open, a data-port write with the index at 0x07 loads it, a data-port read returns it, and `ld_sel` always shows its value.
- R7: The identification registers are read-only. Register 0x20 holds the device ID high byte (default 0x5A) and 0x21 its low byte (0x31). Register 0x22 holds the revision (0x03), 0x23 the manufacturer ID high byte (0x19) and 0x24 its low byte (0x34).
- R8: All other registers below 0x30 read 0x00 and ignore writes.
- R9: While open, a data-port write with the index at 0x30 or above raises `ld_we` for the accepting cycle, with `ld_addr` equal to the index and `ld_wdata` equal to the written byte. A data-port read at such an index returns `ld_rdata` as seen in the accepting cycle.
- R10: With `strap_alt` at 0 the index port is 0x002E and the data port 0x002F; with `strap_alt` at 1 they are 0x004E and 0x004F. Writes to any other address have no effect, and reads of any other address return 0xFF.
- R11: `req_ready` is low exactly while a response is held with `rsp_ready` low. A held response keeps `rsp_data` stable, and each accepted read yields one response in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E/0x2F, 1 gives 0x4E/0x4F |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host I/O address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| ld_sel | output | 8 | Current device selector value |
| ld_addr | output | 8 | Register number for the selected device (the index) |
| ld_wdata | output | 8 | Write byte for the selected device |
| ld_we | output | 1 | One-cycle write strobe for the selected device |
| ld_rdata | input | 8 | Combinational read byte from the selected device |

## Verification
The case that is hardest to reach is a broken key sequence. The block has to tell apart a first 0x87 that is followed by an unrelated index write from two adjacent keys. It also has to ignore data-port traffic between the keys. The stimulus sends 0x87, 0x11, 0x87 and then probes the data port, which must still return 0xFF. One more 0x87 must then open the space. The bench also parks a read response with `rsp_ready` low while a second read waits, which exercises the back-pressure path. A behavioural reference model in the bench predicts each output on every clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_CLOSE  = 8'hAA;
  localparam logic [BYTE_W-1:0] BUS_FLOAT  = 8'hFF;

  localparam logic [BYTE_W-1:0] REG_LDSEL  = 8'h07;
  localparam logic [BYTE_W-1:0] REG_DEV_HI = 8'h20;
  localparam logic [BYTE_W-1:0] REG_DEV_LO = 8'h21;
  localparam logic [BYTE_W-1:0] REG_REV    = 8'h22;
  localparam logic [BYTE_W-1:0] REG_MFR_HI = 8'h23;
  localparam logic [BYTE_W-1:0] REG_MFR_LO = 8'h24;
  localparam logic [BYTE_W-1:0] REG_FWD_LO = 8'h30;

  typedef enum logic {
    LK_SHUT = 1'b0,
    LK_OPEN = 1'b1
  } lock_state_e;

  typedef struct packed {
    logic idx;
    logic dat;
  } port_hit_t;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] addr,
  output port_hit_t         hit
);
  localparam int N_BASE = 2;
  logic [ADDR_W-1:0] base_tab [N_BASE];
  logic [ADDR_W-1:0] base_sel;

  assign base_tab[0] = BASE_PRI;
  assign base_tab[1] = BASE_ALT;
  assign base_sel    = base_tab[strap_alt];

  always_comb begin
    hit.idx = (addr == base_sel);
    hit.dat = (addr == base_sel + ADDR_W'(1));
  end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter int KEY_REPEAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              open_o
);
  localparam int CNT_W = $clog2(KEY_REPEAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_REPEAT - 1);

  lock_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LK_SHUT;
      cnt_q   <= '0;
    end else if (idx_wr) begin
      unique case (state_q)
        LK_SHUT: begin
          if (wdata == KEY_OPEN) begin
            if (cnt_q == CNT_LAST) begin
              state_q <= LK_OPEN;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end else begin
            cnt_q <= '0;
          end
        end
        LK_OPEN: begin
          if (wdata == KEY_CLOSE) begin
            state_q <= LK_SHUT;
            cnt_q   <= '0;
          end
        end
        default: state_q <= LK_SHUT;
      endcase
    end
  end

  assign open_o = (state_q == LK_OPEN);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter logic [15:0]       DEV_ID  = 16'h5A31,
  parameter logic [BYTE_W-1:0] DEV_REV = 8'h03,
  parameter logic [15:0]       MFR_ID  = 16'h1934
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_load,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ext_rdata,
  output logic [BYTE_W-1:0] index_q,
  output logic [BYTE_W-1:0] ldsel_q,
  output logic [BYTE_W-1:0] dat_value,
  output logic              fwd_we
);
  logic fwd_zone;

  assign fwd_zone = (index_q >= REG_FWD_LO);
  assign fwd_we   = dat_wr && fwd_zone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      ldsel_q <= '0;
    end else begin
      if (idx_load) index_q <= wdata;
      if (dat_wr && index_q == REG_LDSEL) ldsel_q <= wdata;
    end
  end

  always_comb begin
    if (fwd_zone) begin
      dat_value = ext_rdata;
    end else begin
      unique case (index_q)
        REG_LDSEL:  dat_value = ldsel_q;
        REG_DEV_HI: dat_value = DEV_ID[15:8];
        REG_DEV_LO: dat_value = DEV_ID[7:0];
        REG_REV:    dat_value = DEV_REV;
        REG_MFR_HI: dat_value = MFR_ID[15:8];
        REG_MFR_LO: dat_value = MFR_ID[7:0];
        default:    dat_value = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_host_if.sv
module cfg_host_if
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] rd_value,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              accept,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI   = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT   = 16'h004E,
  parameter int                KEY_REPEAT = 2,
  parameter logic [15:0]       DEV_ID     = 16'h5A31,
  parameter logic [7:0]        DEV_REV    = 8'h03,
  parameter logic [15:0]       MFR_ID     = 16'h1934
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic [7:0]        ld_sel,
  output logic [7:0]        ld_addr,
  output logic [7:0]        ld_wdata,
  output logic              ld_we,
  input  logic [7:0]        ld_rdata
);
  port_hit_t         hit;
  logic              accept;
  logic              unlocked;
  logic              idx_wr;
  logic              idx_load;
  logic              dat_wr;
  logic [BYTE_W-1:0] index_q;
  logic [BYTE_W-1:0] dat_value;
  logic [BYTE_W-1:0] rd_value;

  cfg_port_decode #(
    .ADDR_W  (ADDR_W),
    .BASE_PRI(BASE_PRI),
    .BASE_ALT(BASE_ALT)
  ) u_dec (
    .strap_alt(strap_alt),
    .addr     (req_addr),
    .hit      (hit)
  );

  assign idx_wr   = accept && req_write && hit.idx;
  assign idx_load = idx_wr && unlocked && (req_wdata != KEY_CLOSE);
  assign dat_wr   = accept && req_write && hit.dat && unlocked;

  cfg_key_fsm #(
    .KEY_REPEAT(KEY_REPEAT)
  ) u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_wr(idx_wr),
    .wdata (req_wdata),
    .open_o(unlocked)
  );

  cfg_reg_bank #(
    .DEV_ID (DEV_ID),
    .DEV_REV(DEV_REV),
    .MFR_ID (MFR_ID)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (idx_load),
    .dat_wr   (dat_wr),
    .wdata    (req_wdata),
    .ext_rdata(ld_rdata),
    .index_q  (index_q),
    .ldsel_q  (ld_sel),
    .dat_value(dat_value),
    .fwd_we   (ld_we)
  );

  always_comb begin
    if (!unlocked)    rd_value = BUS_FLOAT;
    else if (hit.idx) rd_value = index_q;
    else if (hit.dat) rd_value = dat_value;
    else              rd_value = BUS_FLOAT;
  end

  cfg_host_if u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .rd_value (rd_value),
    .rsp_ready(rsp_ready),
    .req_ready(req_ready),
    .accept   (accept),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign ld_addr  = index_q;
  assign ld_wdata = req_wdata;
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_alt,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic [7:0]        ld_sel,
  input logic [7:0]        ld_addr,
  input logic              ld_we,
  input logic              unlocked
);
  logic [ADDR_W-1:0] ck_base;
  logic              ck_acc;
  logic              ck_idx_wr;
  logic              ck_dat_wr;

  assign ck_base   = strap_alt ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
  assign ck_acc    = req_valid && req_ready;
  assign ck_idx_wr = ck_acc && req_write && (req_addr == ck_base);
  assign ck_dat_wr = ck_acc && req_write && (req_addr == ck_base + ADDR_W'(1));

  a_r11_hold_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r11_stall_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r4_shut_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    ck_acc && !req_write && !unlocked |=> rsp_valid && rsp_data == 8'hFF);

  a_r9_we_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> unlocked && ck_dat_wr && ld_addr >= 8'h30);

  a_r3_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked && ck_idx_wr && req_wdata == 8'hAA |=> !unlocked);

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && !(ck_idx_wr && req_wdata == 8'h87) |=> !unlocked);

  a_r6_ldsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ck_dat_wr && unlocked && ld_addr == 8'h07) |=> $stable(ld_sel));
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strap_alt(strap_alt),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .ld_sel   (ld_sel),
  .ld_addr  (ld_addr),
  .ld_we    (ld_we),
  .unlocked (unlocked)
);

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [7:0]  ld_sel;
  logic [7:0]  ld_addr;
  logic [7:0]  ld_wdata;
  logic        ld_we;
  logic [7:0]  ld_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  // Bench-side logical device: register array written on the strobe.
  logic [7:0] dev_mem [256];
  assign ld_rdata = dev_mem[ld_addr];
  always @(posedge clk) if (ld_we) dev_mem[ld_addr] <= ld_wdata;

  cfg_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_we(ld_we),
    .ld_rdata(ld_rdata)
  );

  // Reference model
  bit         m_open;
  int         m_keys;
  logic [7:0] m_idx;
  logic [7:0] m_sel;
  bit         m_rv;
  logic [7:0] m_rd;
  string      m_tag;

  function automatic logic [15:0] base_of();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_keys = 0; m_idx = 8'h00; m_sel = 8'h00; m_rv = 0; m_rd = 8'h00; m_tag = "R1";
    end else begin
      bit acc;
      bit is_i;
      bit is_d;
      acc  = req_valid && (!m_rv || rsp_ready);
      is_i = (req_addr == base_of());
      is_d = (req_addr == base_of() + 16'd1);
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc && req_write) begin
        if (is_i) begin
          if (!m_open) begin
            if (req_wdata == 8'h87) begin
              m_keys++;
              if (m_keys == 2) begin m_open = 1; m_keys = 0; end
            end else m_keys = 0;
          end else if (req_wdata == 8'hAA) begin
            m_open = 0; m_keys = 0;
          end else m_idx = req_wdata;
        end else if (is_d && m_open && m_idx == 8'h07) m_sel = req_wdata;
      end else if (acc) begin
        m_rv = 1;
        if (!is_i && !is_d) begin m_rd = 8'hFF; m_tag = "R10"; end
        else if (!m_open)   begin m_rd = 8'hFF; m_tag = "R4"; end
        else if (is_i)      begin m_rd = m_idx; m_tag = "R5"; end
        else if (m_idx >= 8'h30) begin m_rd = dev_mem[m_idx]; m_tag = "R9"; end
        else begin
          m_tag = "R7";
          case (m_idx)
            8'h07: begin m_rd = m_sel; m_tag = "R6"; end
            8'h20: m_rd = 8'h5A;
            8'h21: m_rd = 8'h31;
            8'h22: m_rd = 8'h03;
            8'h23: m_rd = 8'h19;
            8'h24: m_rd = 8'h34;
            default: begin m_rd = 8'h00; m_tag = "R8"; end
          endcase
        end
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rdy;
      bit e_we;
      e_rdy = !m_rv || rsp_ready;
      e_we  = req_valid && e_rdy && req_write && m_open &&
              (req_addr == base_of() + 16'd1) && (m_idx >= 8'h30);
      check("R11 req_ready", {7'd0, req_ready}, {7'd0, e_rdy});
      check("R11 rsp_valid", {7'd0, rsp_valid}, {7'd0, m_rv});
      if (m_rv) check({m_tag, " rsp_data"}, rsp_data, m_rd);
      check("R9 ld_we", {7'd0, ld_we}, {7'd0, e_we});
      if (e_we) begin
        check("R9 ld_addr", ld_addr, m_idx);
        check("R9 ld_wdata", ld_wdata, req_wdata);
      end
      check("R6 ld_sel", ld_sel, m_sel);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic bus(input logic wr, input logic [15:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    r = 8'h00;
    if (!wr) begin
      forever begin if (rsp_valid) break; @(negedge clk); end
      r = rsp_data;
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] unused;
    bus(1'b1, a, d, unused);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] got;
    bus(1'b0, a, 8'h00, got);
    check(tag, got, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dev_mem[i] = 8'(i ^ 8'h5C);
    dev_mem[8'h31] = 8'h9E;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check("R1 reset req_ready", {7'd0, req_ready}, 8'h01);
    check("R1 reset ld_sel", ld_sel, 8'h00);
    rd_chk("R1 shut after reset", 16'h002F, 8'hFF);

    // R4: locked data write must not reach the selector or the device
    wr(16'h002E, 8'h07);
    wr(16'h002F, 8'h55);
    rd_chk("R4 shut index read", 16'h002E, 8'hFF);

    // R2: broken key sequence, interleaved data write
    wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h11);
    wr(16'h002E, 8'h87);
    rd_chk("R2 still shut", 16'h002F, 8'hFF);
    wr(16'h002F, 8'h33);
    wr(16'h002E, 8'h87);
    rd_chk("R2 opened index zero", 16'h002E, 8'h00);
    check("R4 selector untouched", ld_sel, 8'h00);

    // R5, R6
    wr(16'h002E, 8'h07);
    rd_chk("R5 index readback", 16'h002E, 8'h07);
    wr(16'h002F, 8'h06);
    rd_chk("R6 selector read", 16'h002F, 8'h06);
    check("R6 ld_sel pin", ld_sel, 8'h06);

    // R7 identification
    wr(16'h002E, 8'h20); rd_chk("R7 dev hi", 16'h002F, 8'h5A);
    wr(16'h002E, 8'h21); rd_chk("R7 dev lo", 16'h002F, 8'h31);
    wr(16'h002E, 8'h22); rd_chk("R7 rev", 16'h002F, 8'h03);
    wr(16'h002F, 8'h77); rd_chk("R7 read-only", 16'h002F, 8'h03);
    wr(16'h002E, 8'h23); rd_chk("R7 mfr hi", 16'h002F, 8'h19);
    wr(16'h002E, 8'h24); rd_chk("R7 mfr lo", 16'h002F, 8'h34);

    // R8 reserved
    wr(16'h002E, 8'h15); wr(16'h002F, 8'h44);
    rd_chk("R8 reserved", 16'h002F, 8'h00);
    wr(16'h002E, 8'h2F); rd_chk("R8 below fwd", 16'h002F, 8'h00);

    // R9 forwarding
    wr(16'h002E, 8'h31); rd_chk("R9 device read", 16'h002F, 8'h9E);
    wr(16'h002E, 8'h40); wr(16'h002F, 8'hC3);
    rd_chk("R9 device write back", 16'h002F, 8'hC3);

    // R10 foreign addresses
    rd_chk("R10 foreign read", 16'h004E, 8'hFF);
    wr(16'h004F, 8'h12);
    rd_chk("R10 foreign write ignored", 16'h002F, 8'hC3);

    // R11 back-pressure: hold a response while another read waits
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h002E;
    @(posedge clk); #1;
    req_addr = 16'h002F;
    repeat (3) begin
      @(negedge clk);
      check("R11 stalled ready", {7'd0, req_ready}, 8'h00);
      check("R11 held data", rsp_data, 8'h40);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R11 second response", rsp_data, 8'hC3);
    @(posedge clk); #1;

    // R3 close
    wr(16'h002E, 8'hAA);
    rd_chk("R3 shut after close", 16'h002F, 8'hFF);
    wr(16'h002F, 8'h01);

    // R10 strap to alternate base
    strap_alt = 1'b1;
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    rd_chk("R3 index kept across close", 16'h004E, 8'h40);
    rd_chk("R10 alt data port", 16'h004F, 8'hC3);
    rd_chk("R10 old base now foreign", 16'h002F, 8'hFF);
    check("R6 selector kept", ld_sel, 8'h06);

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule